// File: doc/BRIEF.md
# Hardware Lock Bank

A bank of hardware lock bits shared by several processors that have no other way to exclude each other. Each lock has its own 32-bit register. A read of that register is a test-and-set: it returns whether the lock was already held and leaves the lock held. A processor releases a lock by writing zero to the same register. It keeps reading until the read returns 0, and at that point it owns the lock.

Several requester ports feed a fixed-priority arbiter that serves one access per clock. Every port that is not served is held off through its ready signal. A read-only bitmap register shows the state of locks 0 to 31. A read-only identification register reports how many locks were built. The bank can be built with 32, 64, 128 or 256 locks.

Top module: `hwlock_bank`

## Requirements
- R1: The register at offset 0x000 is read-only. Bits [1:0] hold the lock-count code: 0 for 32 locks, 1 for 64, 2 for 128 and 3 for 256. All other bits read 0.
- R2: A read of lock register n (offset 0x100 + 4*n, word aligned, n below the lock count) returns 0 when lock n is free. The same access marks lock n as taken.
- R3: A read of a lock register whose lock is already taken returns 1 and leaves the lock taken.
- R4: A write of 0 to lock register n frees lock n.
- R5: A write of a nonzero value to a lock register changes no lock.
- R6: The register at offset 0x010 returns, in bit n, the state of lock n for n = 0..31, where 1 means taken. Reading it changes no lock, and writing it has no effect.
- R7: An access to any offset not covered by R1, R2 or R6 reads as 0 and changes no lock. This includes non-aligned offsets and lock offsets at or beyond the lock count.
- R8: Only one request is served per cycle, and the served port sees ready_o high in that cycle. Among the ports whose valid is high, the port with the lowest index is served. A port that is not served sees ready_o low and keeps its request pending.
- R9: The response of a served access appears on that port's rsp_valid_o and rsp_rdata_o in the next cycle. Its lock update takes effect at the same clock edge. A write returns rdata 0.
- R10: After reset all locks are free.
- R11: When several ports read the same free lock in the same cycle, exactly one of them receives 0. Every other port receives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Request valid, one bit per port |
| req_write_i | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| req_addr_i | input | NUM_PORTS*ADDR_W | Byte offset, port p at bits [p*ADDR_W +: ADDR_W] |
| req_wdata_i | input | NUM_PORTS*32 | Write data, port p at bits [p*32 +: 32] |
| req_ready_o | output | NUM_PORTS | Request accepted this cycle |
| rsp_valid_o | output | NUM_PORTS | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | NUM_PORTS*32 | Response data, port p at bits [p*32 +: 32] |

## Verification
The hardest case is a true collision: two or more ports reading the same free lock in the same cycle, where the arbiter alone decides who wins. Driving one port at a time can never reach this case. The stimulus therefore raises all three valids together on one lock offset. It drops each port's valid only after that port has been served, and it checks the ready pattern and the returned 0/1 in every cycle of the drain. Around this directed case, randomly chosen single-port reads, releases, nonzero writes, status reads and unmapped accesses are compared against a bench model of the lock bits.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_LOCK = 2'd3
  } sel_e;

  localparam int unsigned ID_OFS    = 32'h000;
  localparam int unsigned STAT_OFS  = 32'h010;
  localparam int unsigned LOCK_BASE = 32'h100;
  localparam int unsigned DATA_W    = 32;
endpackage

// File: rtl/hwlock_arb.sv
module hwlock_arb #(
  parameter int unsigned N = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (valid_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hwlock_decode.sv
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [LIDX_W-1:0] idx_o
);
  localparam logic [ADDR_W:0] LOCK_LO = (ADDR_W+1)'(LOCK_BASE);
  localparam logic [ADDR_W:0] LOCK_HI = (ADDR_W+1)'(LOCK_BASE + 4 * NUM_LOCKS);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] offs;

  assign addr_x = {1'b0, addr_i};
  assign offs   = addr_x - LOCK_LO;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (addr_x == (ADDR_W+1)'(ID_OFS)) begin
      sel_o = SEL_ID;
    end else if (addr_x == (ADDR_W+1)'(STAT_OFS)) begin
      sel_o = SEL_STAT;
    end else if (addr_x >= LOCK_LO && addr_x < LOCK_HI && addr_i[1:0] == 2'b00) begin
      sel_o = SEL_LOCK;
      idx_o = offs[LIDX_W+1:2];
    end
  end
endmodule

// File: rtl/hwlock_store.sv
module hwlock_store #(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 take_i,
  input  logic                 free_i,
  input  logic [LIDX_W-1:0]    idx_i,
  output logic [NUM_LOCKS-1:0] lock_q
);
  logic [NUM_LOCKS-1:0] set_vec;
  logic [NUM_LOCKS-1:0] clr_vec;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    assign set_vec[g] = take_i && (idx_i == LIDX_W'(g));
    assign clr_vec[g] = free_i && (idx_i == LIDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else         lock_q <= (lock_q | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        req_valid_i,
  input  logic [NUM_PORTS-1:0]        req_write_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] req_addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0] req_wdata_i,
  output logic [NUM_PORTS-1:0]        req_ready_o,
  output logic [NUM_PORTS-1:0]        rsp_valid_o,
  output logic [NUM_PORTS*DATA_W-1:0] rsp_rdata_o
);
  localparam int unsigned LIDX_W   = $clog2(NUM_LOCKS);
  localparam int unsigned PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned CNT_CODE = LIDX_W - 5;

  logic [NUM_PORTS-1:0] grant;
  logic [PIDX_W-1:0]    gidx;
  logic                 any_gnt;
  logic [ADDR_W-1:0]    sel_addr;
  logic [DATA_W-1:0]    sel_wdata;
  logic                 sel_wr;
  sel_e                 sel;
  logic [LIDX_W-1:0]    lidx;
  logic                 take, free;
  logic [NUM_LOCKS-1:0] lock_state;
  logic [DATA_W-1:0]    rdata_d, rdata_q;
  logic [NUM_PORTS-1:0] rvalid_q;

  hwlock_arb #(.N(NUM_PORTS)) u_arb (
    .valid_i(req_valid_i),
    .grant_o(grant),
    .idx_o  (gidx),
    .any_o  (any_gnt)
  );

  assign req_ready_o = grant;
  assign sel_addr    = req_addr_i[gidx*ADDR_W +: ADDR_W];
  assign sel_wdata   = req_wdata_i[gidx*DATA_W +: DATA_W];
  assign sel_wr      = req_write_i[gidx];

  hwlock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(sel_addr),
    .sel_o (sel),
    .idx_o (lidx)
  );

  // read is the test-and-set; only an all-zero write frees
  assign take = any_gnt && !sel_wr && (sel == SEL_LOCK);
  assign free = any_gnt &&  sel_wr && (sel == SEL_LOCK) && (sel_wdata == '0);

  hwlock_store #(.NUM_LOCKS(NUM_LOCKS)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .free_i(free),
    .idx_i (lidx),
    .lock_q(lock_state)
  );

  always_comb begin
    rdata_d = '0;
    if (!sel_wr) begin
      unique case (sel)
        SEL_ID:   rdata_d = DATA_W'(CNT_CODE);
        SEL_STAT: rdata_d = lock_state[31:0];
        SEL_LOCK: rdata_d = DATA_W'(lock_state[lidx]);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= '0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= grant;
      if (any_gnt) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid_o = rvalid_q;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
    assign rsp_rdata_o[p*DATA_W +: DATA_W] = rvalid_q[p] ? rdata_q : '0;
  end
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned NUM_LOCKS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PORTS-1:0] req_valid_i,
  input logic [NUM_PORTS-1:0] req_ready_o,
  input logic [NUM_PORTS-1:0] rsp_valid_o,
  input logic [NUM_LOCKS-1:0] lock_state_i
);
  a_r8_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  a_r8_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);

  a_r8_no_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_valid_i) |-> (|req_ready_o));

  a_r9_single_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lock_state_i ^ $past(lock_state_i)) <= 1);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    a_r9_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o[p] |=> rsp_valid_o[p]);
    a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_ready_o[p] |=> !rsp_valid_o[p]);
    if (p > 0) begin : g_prio
      a_r8_low_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o[p] |-> (req_valid_i[p-1:0] == '0));
    end
  end
endmodule

bind hwlock_bank hwlock_bank_chk #(.NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .lock_state_i(lock_state)
);

// File: tb/sim_hwlock_bank.sv
module sim_hwlock_bank;
  localparam int NP = 3;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] valid = '0, wr = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*32-1:0] wdata = '0;
  logic [NP-1:0] ready, rvalid;
  logic [NP*32-1:0] rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] mdl = '0;

  always #2 clk_i = ~clk_i;

  hwlock_bank #(.NUM_PORTS(NP), .NUM_LOCKS(32), .ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(valid), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(ready),
    .rsp_valid_o(rvalid), .rsp_rdata_o(rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a == 12'h000) return 32'd0;
    if (a == 12'h010) return mdl;
    if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) return {31'b0, mdl[(a - 12'h100) >> 2]};
    return 32'd0;
  endfunction

  function automatic void mdl_update(input logic w, input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) begin
      if (!w) mdl[(a - 12'h100) >> 2] = 1'b1;
      else if (d == 32'd0) mdl[(a - 12'h100) >> 2] = 1'b0;
    end
  endfunction

  task automatic access(input int p, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
    logic [31:0] e;
    @(negedge clk_i);
    valid[p] = 1'b1; wr[p] = w;
    addr[p*AW +: AW] = a; wdata[p*32 +: 32] = d;
    #1;
    check({tag, " R8 ready"}, 32'(ready), 32'(1 << p));
    e = w ? 32'd0 : exp_read(a);
    @(posedge clk_i); #1;
    check({tag, " R9 rsp_valid"}, 32'(rvalid), 32'(1 << p));
    check(tag, rdata[p*32 +: 32], e);
    mdl_update(w, a, d);
    valid[p] = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    check("R9 idle rsp_valid", 32'(rvalid), 32'd0);

    access(0, 1'b0, 12'h010, 32'd0, "R10 status after reset");
    access(1, 1'b0, 12'h000, 32'd0, "R1 id register");
    access(2, 1'b1, 12'h000, 32'h3, "R1 write id");
    access(2, 1'b0, 12'h000, 32'd0, "R1 id unchanged");

    // sweep: take every lock, retake, check status, free
    for (int n = 0; n < 32; n++) access(n % NP, 1'b0, 12'(12'h100 + 4 * n), 0, "R2 take free");
    for (int n = 0; n < 32; n += 7) access(1, 1'b0, 12'(12'h100 + 4 * n), 0, "R3 retake held");
    access(0, 1'b0, 12'h010, 0, "R6 status all taken");
    access(1, 1'b1, 12'h010, 32'd0, "R6 write status");
    access(1, 1'b0, 12'h010, 0, "R6 status unchanged");
    access(2, 1'b1, 12'h104, 32'h1, "R5 nonzero write");
    access(2, 1'b0, 12'h104, 0, "R5 lock still held");
    for (int n = 0; n < 32; n++) access(2, 1'b1, 12'(12'h100 + 4 * n), 32'd0, "R4 free");
    access(0, 1'b0, 12'h010, 0, "R4 status all free");

    // unmapped: beyond last lock, misaligned, gaps
    access(0, 1'b0, 12'h180, 0, "R7 past last lock");
    access(0, 1'b0, 12'h101, 0, "R7 misaligned");
    access(1, 1'b0, 12'h004, 0, "R7 gap");
    access(0, 1'b1, 12'h180, 32'd0, "R7 write past end");
    access(0, 1'b0, 12'h010, 0, "R7 status untouched");

    // collision on lock 5
    @(negedge clk_i);
    valid = 3'b111; wr = 3'b000;
    for (int p = 0; p < NP; p++) addr[p*AW +: AW] = 12'h114;
    for (int p = 0; p < NP; p++) begin
      #1;
      check("R8 R11 collision ready", 32'(ready), 32'(1 << p));
      @(posedge clk_i); #1;
      check("R11 collision rsp_valid", 32'(rvalid), 32'(1 << p));
      check("R11 collision data", rdata[p*32 +: 32], (p == 0) ? 32'd0 : 32'd1);
      valid[p] = 1'b0;
      @(negedge clk_i);
    end
    mdl[5] = 1'b1;
    access(0, 1'b0, 12'h010, 0, "R11 status after collision");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int p, c;
      logic [11:0] a;
      logic w;
      logic [31:0] d;
      p = int'($urandom_range(NP - 1));
      c = int'($urandom_range(99));
      w = 1'($urandom_range(1));
      if (c < 65) a = 12'(12'h100 + 4 * $urandom_range(31));
      else if (c < 80) a = 12'h010;
      else if (c < 88) a = 12'h000;
      else begin
        case ($urandom_range(3))
          0: a = 12'h180;
          1: a = 12'h10A;
          2: a = 12'h020;
          default: a = 12'hFFC;
        endcase
      end
      d = ($urandom_range(1) == 0) ? 32'd0 : ($urandom | 32'd1);
      access(p, w, a, d, "R2 R3 R4 R5 R6 R7 random");
    end
    access(0, 1'b0, 12'h010, 0, "R6 final status");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule